// File: doc/BRIEF.md
# Vectored Interrupt Request Tracker

This block keeps interrupt bookkeeping for one processor across 256 numbered vectors. It holds three 256-bit state vectors: the enable mask, the pending requests and the vectors being serviced. Each has one bit per vector, arranged as 32 lanes of 8 bits. A raise strobe names a vector to request. The request is latched only if that vector is enabled; a raise for a disabled vector is discarded.

Vector number decides priority: a larger number wins. The block reports combinationally whether anything is pending and which pending vector has the largest number. When the processor acknowledges a vector, that vector moves from pending to in service. An end-of-interrupt strobe retires the in-service vector with the largest number.

Software fills the enable mask one lane at a time through a byte-wide write port. The block also reports the largest in-service vector, so that retirement can be observed from outside.

Top module: `vec_irq_tracker`

## Requirements
- R1: A synchronous active-high reset clears the enable, request and in-service state. After reset `pend_any` and `svc_any` are 0, `pend_vec` and `svc_vec` read 0, and a raise of any vector is dropped.
- R2: When `en_wr` is high, `en_wr_data` replaces the 8 enable bits of lane `en_wr_idx`. Vector v sits in lane v>>3 at bit v[2:0], so `en_wr_data[b]` enables vector `en_wr_idx`*8+b.
- R3: A raise of a vector whose enable bit is 0 changes no state.
- R4: A raise of an enabled vector sets its request bit from the next cycle on.
- R5: `pend_vec` is, combinationally, the largest vector number whose request bit is set, and reads 0 when none is set.
- R6: `pend_any` is 1 exactly when at least one request bit is set.
- R7: An acknowledge clears the request bit of `ack_vec` and sets its in-service bit, taking effect in the next cycle.
- R8: An end-of-interrupt clears only the largest-numbered in-service bit and has no effect when none is set. `svc_any` and `svc_vec` report the in-service state in the same way that `pend_any` and `pend_vec` report requests.
- R9: When a raise and an acknowledge name the same enabled vector in the same cycle, the acknowledge is applied first and then the raise. The request bit therefore stays set and the in-service bit is set.
- R10: When an end-of-interrupt and an acknowledge fall in the same cycle, the end-of-interrupt retires the largest in-service bit as it stood before that cycle, and the acknowledged bit is set.
- R11: A raise is judged against the enable value from before any enable write in the same cycle. Clearing an enable bit does not remove a request that is already latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_vld | input | 1 | Raise strobe |
| raise_vec | input | 8 | Vector to raise |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_vec | input | 8 | Vector to acknowledge |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| en_wr | input | 1 | Enable lane write strobe |
| en_wr_idx | input | 5 | Enable lane index |
| en_wr_data | input | 8 | New enable bits for the lane |
| pend_any | output | 1 | Some request is pending |
| pend_vec | output | 8 | Largest pending vector, 0 if none |
| svc_any | output | 1 | Some vector is in service |
| svc_vec | output | 8 | Largest in-service vector, 0 if none |

## Verification
Several pairs of operations can fall in the same cycle: raise with acknowledge on the same vector, acknowledge with end-of-interrupt, and raise with an enable write that covers the raised vector. The bench provokes each pair with directed steps. It then runs a long random phase in which the strobes overlap freely. A behavioural model applies the ordering rules of R9, R10 and R11, and the four outputs are compared with it after every clock.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int VEC_W      = 8;
    localparam int NUM_VEC    = 1 << VEC_W;
    localparam int LANE_BIT_W = 3;
    localparam int LANE_BITS  = 1 << LANE_BIT_W;
    localparam int NUM_LANES  = NUM_VEC / LANE_BITS;
    localparam int LANE_IDX_W = VEC_W - LANE_BIT_W;

    typedef logic [VEC_W-1:0]      vec_t;
    typedef logic [NUM_VEC-1:0]    vmask_t;
    typedef logic [LANE_IDX_W-1:0] lane_idx_t;
    typedef logic [LANE_BITS-1:0]  lane_t;

    typedef struct packed {
        logic vld;
        vec_t num;
    } vec_cmd_t;

    typedef struct packed {
        logic      vld;
        lane_idx_t idx;
        lane_t     data;
    } en_cmd_t;

    typedef struct packed {
        logic any;
        vec_t top;
    } prio_t;

    function automatic vmask_t vec_onehot(input vec_cmd_t c);
        vmask_t m;
        m = '0;
        if (c.vld) m[c.num] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/vit_lane_find.sv
module vit_lane_find #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  bits_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |bits_i;
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (bits_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/vit_prio_enc.sv
module vit_prio_enc
    import vit_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int LBITS = LANE_BITS,
    localparam int LIW  = $clog2(LBITS),
    localparam int GIW  = $clog2(LANES),
    localparam int TOTAL = LANES * LBITS
) (
    input  logic [TOTAL-1:0]     bits_i,
    output logic                 any_o,
    output logic [GIW+LIW-1:0]   top_o
);
    logic [LANES-1:0] lane_any;
    logic [LIW-1:0]   lane_idx [LANES];
    logic [GIW-1:0]   grp;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vit_lane_find #(.W(LBITS)) u_lane (
            .bits_i (bits_i[g*LBITS +: LBITS]),
            .any_o  (lane_any[g]),
            .idx_o  (lane_idx[g])
        );
    end

    vit_lane_find #(.W(LANES)) u_group (
        .bits_i (lane_any),
        .any_o  (any_o),
        .idx_o  (grp)
    );

    assign top_o = {grp, lane_idx[grp]};
endmodule

// File: rtl/vit_vec_bank.sv
module vit_vec_bank
    import vit_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  vec_cmd_t raise_i,
    input  vec_cmd_t ack_i,
    input  vmask_t   eoi_clr_i,
    input  en_cmd_t  en_i,
    output vmask_t   req_q,
    output vmask_t   en_q,
    output vmask_t   isr_q
);
    vmask_t raise_mask, ack_mask, req_d, isr_d;

    always_comb begin
        raise_mask = vec_onehot(raise_i) & en_q;
        ack_mask   = vec_onehot(ack_i);
        req_d      = (req_q & ~ack_mask) | raise_mask;
        isr_d      = (isr_q & ~eoi_clr_i) | ack_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            isr_q <= '0;
        end else begin
            req_q <= req_d;
            isr_q <= isr_d;
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst)
                en_q[g*LANE_BITS +: LANE_BITS] <= '0;
            else if (en_i.vld && en_i.idx == lane_idx_t'(g))
                en_q[g*LANE_BITS +: LANE_BITS] <= en_i.data;
        end
    end

    p_en_write_r2: assert property (@(posedge clk) disable iff (rst)
        en_i.vld |=> en_q[{$past(en_i.idx), 3'b000} +: LANE_BITS] == $past(en_i.data));

    p_drop_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        (raise_i.vld && !en_q[raise_i.num] && !(ack_i.vld && ack_i.num == raise_i.num))
        |=> req_q[$past(raise_i.num)] == $past(req_q[raise_i.num]));

    p_raise_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (raise_i.vld && en_q[raise_i.num]) |=> req_q[$past(raise_i.num)]);

    p_ack_moves_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_i.vld && !(raise_i.vld && raise_i.num == ack_i.num))
        |=> (!req_q[$past(ack_i.num)] && isr_q[$past(ack_i.num)]));

    p_same_vec_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_i.vld && raise_i.vld && raise_i.num == ack_i.num && en_q[raise_i.num])
        |=> (req_q[$past(ack_i.num)] && isr_q[$past(ack_i.num)]));
endmodule

// File: rtl/vec_irq_tracker.sv
module vec_irq_tracker
    import vit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raise_vld,
    input  logic [7:0] raise_vec,
    input  logic       ack_vld,
    input  logic [7:0] ack_vec,
    input  logic       eoi_vld,
    input  logic       en_wr,
    input  logic [4:0] en_wr_idx,
    input  logic [7:0] en_wr_data,
    output logic       pend_any,
    output logic [7:0] pend_vec,
    output logic       svc_any,
    output logic [7:0] svc_vec
);
    vec_cmd_t raise_c, ack_c, retire_c;
    en_cmd_t  en_c;
    vmask_t   req_q, en_q, isr_q, eoi_clr;
    prio_t    pend_p, svc_p;

    assign raise_c  = '{vld: raise_vld, num: raise_vec};
    assign ack_c    = '{vld: ack_vld, num: ack_vec};
    assign en_c     = '{vld: en_wr, idx: en_wr_idx, data: en_wr_data};
    assign retire_c = '{vld: eoi_vld && svc_p.any, num: svc_p.top};
    assign eoi_clr  = vec_onehot(retire_c);

    vit_vec_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .raise_i   (raise_c),
        .ack_i     (ack_c),
        .eoi_clr_i (eoi_clr),
        .en_i      (en_c),
        .req_q     (req_q),
        .en_q      (en_q),
        .isr_q     (isr_q)
    );

    vit_prio_enc u_pend_enc (
        .bits_i (req_q),
        .any_o  (pend_p.any),
        .top_o  (pend_p.top)
    );

    vit_prio_enc u_svc_enc (
        .bits_i (isr_q),
        .any_o  (svc_p.any),
        .top_o  (svc_p.top)
    );

    assign pend_any = pend_p.any;
    assign pend_vec = pend_p.top;
    assign svc_any  = svc_p.any;
    assign svc_vec  = svc_p.top;

    p_pend_top_r5: assert property (@(posedge clk) disable iff (rst)
        pend_any |-> ((req_q >> pend_vec) == vmask_t'(1)));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !pend_any |-> (pend_vec == '0));

    p_flag_r6: assert property (@(posedge clk) disable iff (rst)
        pend_any == (req_q != '0));

    p_eoi_single_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi_vld && !ack_vld) |=>
        (($past(isr_q) == '0) ? (isr_q == '0)
                              : ($countones(isr_q) + 1 == $countones($past(isr_q)))));

    p_eoi_top_r10: assert property (@(posedge clk) disable iff (rst)
        (eoi_vld && svc_any && !(ack_vld && ack_vec == svc_vec))
        |=> !isr_q[$past(svc_vec)]);
endmodule

// File: tb/test_vec_irq_tracker.sv
module test_vec_irq_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raise_vld = 1'b0;
    logic [7:0] raise_vec = '0;
    logic       ack_vld = 1'b0;
    logic [7:0] ack_vec = '0;
    logic       eoi_vld = 1'b0;
    logic       en_wr = 1'b0;
    logic [4:0] en_wr_idx = '0;
    logic [7:0] en_wr_data = '0;
    logic       pend_any, svc_any;
    logic [7:0] pend_vec, svc_vec;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [255:0] m_req = '0, m_en = '0, m_isr = '0;

    always #10 clk = ~clk;

    vec_irq_tracker i_vec_irq_tracker (
        .clk(clk), .rst(rst),
        .raise_vld(raise_vld), .raise_vec(raise_vec),
        .ack_vld(ack_vld), .ack_vec(ack_vec),
        .eoi_vld(eoi_vld),
        .en_wr(en_wr), .en_wr_idx(en_wr_idx), .en_wr_data(en_wr_data),
        .pend_any(pend_any), .pend_vec(pend_vec),
        .svc_any(svc_any), .svc_vec(svc_vec)
    );

    function automatic int top_of(input logic [255:0] v);
        for (int i = 255; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        logic [255:0] nr, ne, ni;
        int t;
        @(posedge clk);
        nr = m_req; ne = m_en; ni = m_isr;
        if (ack_vld) nr[ack_vec] = 1'b0;
        if (raise_vld && m_en[raise_vec]) nr[raise_vec] = 1'b1;
        t = top_of(m_isr);
        if (eoi_vld && t >= 0) ni[t] = 1'b0;
        if (ack_vld) ni[ack_vec] = 1'b1;
        if (en_wr) ne[int'(en_wr_idx)*8 +: 8] = en_wr_data;
        if (rst) begin nr = '0; ne = '0; ni = '0; end
        m_req = nr; m_en = ne; m_isr = ni;
        @(negedge clk);
        raise_vld = 1'b0; ack_vld = 1'b0; eoi_vld = 1'b0; en_wr = 1'b0;
        t = top_of(m_req);
        chk(pend_any == (t >= 0), "R6 pend_any vs model", int'(pend_any), int'(t >= 0));
        chk(int'(pend_vec) == ((t < 0) ? 0 : t), "R5 pend_vec vs model", int'(pend_vec), (t < 0) ? 0 : t);
        t = top_of(m_isr);
        chk(svc_any == (t >= 0), "R8 svc_any vs model", int'(svc_any), int'(t >= 0));
        chk(int'(svc_vec) == ((t < 0) ? 0 : t), "R8 svc_vec vs model", int'(svc_vec), (t < 0) ? 0 : t);
    endtask

    task automatic do_raise(input int v);
        raise_vld = 1'b1; raise_vec = 8'(v); cyc();
    endtask
    task automatic do_ack(input int v);
        ack_vld = 1'b1; ack_vec = 8'(v); cyc();
    endtask
    task automatic do_eoi();
        eoi_vld = 1'b1; cyc();
    endtask
    task automatic do_en(input int idx, input int data);
        en_wr = 1'b1; en_wr_idx = 5'(idx); en_wr_data = 8'(data); cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        cyc(); cyc(); cyc();
        rst = 1'b0;
        // R1: reset state
        chk(!pend_any && pend_vec == 0, "R1 pending after reset", int'(pend_vec), 0);
        chk(!svc_any && svc_vec == 0, "R1 in-service after reset", int'(svc_vec), 0);
        do_raise(5);
        chk(!pend_any, "R1 enables cleared by reset", int'(pend_any), 0);

        // R2: lane 31 bits 5,7 -> vectors 253,255; lane 2 bit 0 -> vector 16
        do_en(31, 8'hA0);
        do_en(2, 8'h01);
        do_raise(16);
        chk(pend_any && pend_vec == 16, "R4 raise enabled 16", int'(pend_vec), 16);
        do_raise(253);
        chk(pend_vec == 253, "R2 R5 lane 31 bit 5 enabled", int'(pend_vec), 253);
        do_raise(254);
        chk(pend_vec == 253, "R3 disabled 254 dropped", int'(pend_vec), 253);
        do_raise(255);
        chk(pend_vec == 255, "R5 highest pending", int'(pend_vec), 255);

        // R7
        do_ack(255);
        chk(pend_vec == 253 && svc_vec == 255, "R7 ack moves 255", int'(pend_vec), 253);
        do_ack(253);
        chk(pend_vec == 16 && svc_vec == 255, "R7 ack moves 253", int'(svc_vec), 255);

        // R8
        do_eoi();
        chk(svc_any && svc_vec == 253, "R8 eoi retires only 255", int'(svc_vec), 253);
        do_eoi();
        chk(!svc_any, "R8 eoi retires 253", int'(svc_any), 0);
        do_eoi();
        chk(!svc_any && pend_vec == 16, "R8 eoi with none in service", int'(svc_any), 0);

        // R9: raise and ack of 16 together
        raise_vld = 1'b1; raise_vec = 8'd16;
        do_ack(16);
        chk(pend_any && pend_vec == 16, "R9 request stays set", int'(pend_vec), 16);
        chk(svc_vec == 16, "R9 in-service set", int'(svc_vec), 16);

        // R10: ack 253 with eoi; eoi retires 16
        do_raise(253);
        eoi_vld = 1'b1;
        do_ack(253);
        chk(svc_vec == 253, "R10 ack with eoi, higher ack", int'(svc_vec), 253);
        eoi_vld = 1'b1;
        do_ack(16);
        chk(svc_vec == 16, "R10 eoi retires 253, 16 set", int'(svc_vec), 16);
        do_eoi();
        chk(!svc_any, "R10 only one bit left", int'(svc_any), 0);

        // R11: enable write in same cycle as raise
        do_ack(16);
        do_eoi();
        chk(!pend_any, "R11 setup empty", int'(pend_any), 0);
        raise_vld = 1'b1; raise_vec = 8'd8;
        do_en(1, 8'hFF);
        chk(!pend_any, "R11 raise uses old enable", int'(pend_any), 0);
        do_raise(8);
        chk(pend_vec == 8, "R11 raise after enable", int'(pend_vec), 8);
        do_en(1, 8'h00);
        chk(pend_vec == 8, "R11 disable keeps request", int'(pend_vec), 8);

        // random overlap phase, model compared each cycle
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(99) < 60) begin raise_vld = 1'b1; raise_vec = 8'($urandom_range(255)); end
            if ($urandom_range(99) < 30) begin ack_vld = 1'b1; ack_vec = ($urandom_range(1) == 1 && pend_any) ? pend_vec : 8'($urandom_range(255)); end
            if ($urandom_range(99) < 25) eoi_vld = 1'b1;
            if ($urandom_range(99) < 10) begin
                en_wr = 1'b1; en_wr_idx = 5'($urandom_range(31)); en_wr_data = 8'($urandom_range(255));
            end
            if ($urandom_range(99) < 5) begin raise_vld = 1'b1; ack_vld = 1'b1; ack_vec = raise_vec; end
            cyc();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule